// File: doc/BRIEF.md
# Programmable Flag Offset Registers

This block holds the two thresholds that a FIFO's programmable flags are compared against. The empty offset sets how few words count as "almost empty" and the full offset sets how close to full counts as "almost full". The flag comparison logic is not part of this block. It only consumes the two offsets.

A master reset does two things at once. It latches the load-mode pin, which selects serial or parallel loading for the whole time until the next reset. It also loads both offsets with one of eight default values. The default is chosen by a three-bit index built from the load-mode pin and the two default-select pins.

After reset, software can rewrite the offsets:
- In parallel mode, it writes them over the parallel data bus.
- In serial mode, it shifts them in one bit per clock.

In either mode, the current offsets can be read back over the parallel read-back bus, one per request.

Top module: `fo_offset_regs`

## Requirements
- R1: On a clock edge with `rst` high, `load_mode` is latched. A 1 selects serial loading and a 0 selects parallel loading. The choice holds until the next reset.
- R2: A reset loads both `empty_ofs` and `full_ofs` with the default 2^(idx+3)-1, limited to DEPTH-1. Here idx = {load_mode, dflt_sel[1], dflt_sel[0]}, so the value is 7 for idx 0 and 1023 for idx 7 when DEPTH is 1024.
- R3: In parallel mode, each cycle with `par_we` high writes `par_din` into one offset, alternating between them. The first write after reset goes to the empty offset and the next to the full offset. The new value appears on the output the cycle after the edge.
- R4: A parallel value greater than DEPTH-1 is stored as DEPTH-1.
- R5: In serial mode, each cycle with `ser_en` high stores `ser_din` as one offset bit, least significant bit first. The first OW bits go to the empty offset and the next OW bits go to the full offset, and then the sequence starts again with the empty offset.
- R6: Mode gating:
  - In serial mode, `par_we` changes neither offset.
  - In parallel mode, `ser_en` changes neither offset.
  - With no load strobe active, both offsets hold their values.
- R7: Each cycle with `rd_req` high places one offset, zero-extended, on `rd_data` the next cycle. The order is empty offset, then full offset, and then it wraps back to the empty offset. This works in both modes. Without `rd_req`, `rd_data` holds its value.
- R8: A reset clears `rd_data` to 0. It also returns the parallel write order, the read-back order and the serial bit position to their starting points (the empty offset, bit 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock |
| rst | input | 1 | Synchronous active-high master reset |
| load_mode | input | 1 | Loading method sampled at reset (1 serial, 0 parallel) |
| dflt_sel | input | 2 | Default offset select sampled at reset |
| par_we | input | 1 | Parallel offset write strobe |
| par_din | input | DATA_W | Parallel offset value |
| ser_en | input | 1 | Serial shift enable |
| ser_din | input | 1 | Serial offset bit |
| rd_req | input | 1 | Read-back request |
| empty_ofs | output | OW | Current empty offset n |
| full_ofs | output | OW | Current full offset m |
| rd_data | output | DATA_W | Read-back data |

## Verification
Faults in different parts of the state show up in different ways:
- **Latched mode:** if it is wrong, the strobe of the other loading method starts changing the offsets on the very next cycle.
- **Parallel or read-back pointer:** if one is out of step, the wrong offset is updated or returned on the first strobe or request after reset.
- **Serial bit counter:** if it slips, a shifted value lands in the wrong bit or the wrong register. This only becomes visible once a full word has been shifted in.
- **Default decode or clipping:** an error here is visible on the offset outputs one cycle after the reset or write that caused it.

// File: rtl/fo_pkg.sv
package fo_pkg;
  typedef enum logic { TGT_EMPTY = 1'b0, TGT_FULL = 1'b1 } ofs_tgt_e;
  localparam int NUM_DEFAULTS = 8;
  localparam int DFLT_BASE_SHIFT = 3;
endpackage

// File: rtl/fo_defaults.sv
module fo_defaults #(
  parameter int DEPTH = 1024,
  parameter int OW    = $clog2(DEPTH)
) (
  input  logic [2:0]    idx,
  output logic [OW-1:0] value
);
  import fo_pkg::*;
  logic [OW-1:0] tbl [NUM_DEFAULTS];

  for (genvar i = 0; i < NUM_DEFAULTS; i++) begin : g_tbl
    localparam longint RAW = (64'd1 << (i + DFLT_BASE_SHIFT)) - 64'd1;
    localparam longint LIM = (RAW > DEPTH - 1) ? DEPTH - 1 : RAW;
    assign tbl[i] = OW'(LIM);
  end

  assign value = tbl[idx];
endmodule

// File: rtl/fo_ser_ctrl.sv
module fo_ser_ctrl #(
  parameter int OW = 10,
  parameter int BW = (OW > 1) ? $clog2(OW) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            step,
  output fo_pkg::ofs_tgt_e tgt,
  output logic [BW-1:0]   bit_idx
);
  import fo_pkg::*;
  localparam logic [BW-1:0] LAST = BW'(OW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt     <= TGT_EMPTY;
      bit_idx <= '0;
    end else if (step) begin
      if (bit_idx == LAST) begin
        bit_idx <= '0;
        tgt     <= (tgt == TGT_EMPTY) ? TGT_FULL : TGT_EMPTY;
      end else begin
        bit_idx <= bit_idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fo_par_ctrl.sv
module fo_par_ctrl #(
  parameter int DEPTH  = 1024,
  parameter int OW     = $clog2(DEPTH),
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [DATA_W-1:0] din,
  output fo_pkg::ofs_tgt_e  tgt,
  output logic [OW-1:0]     clipped
);
  import fo_pkg::*;
  localparam logic [DATA_W-1:0] MAXV = DATA_W'(DEPTH - 1);

  always_comb begin
    if (din > MAXV) clipped = OW'(DEPTH - 1);
    else            clipped = din[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       tgt <= TGT_EMPTY;
    else if (step) tgt <= (tgt == TGT_EMPTY) ? TGT_FULL : TGT_EMPTY;
  end
endmodule

// File: rtl/fo_readback.sv
module fo_readback #(
  parameter int OW     = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [OW-1:0]     empty_v,
  input  logic [OW-1:0]     full_v,
  output logic [DATA_W-1:0] dout
);
  import fo_pkg::*;
  ofs_tgt_e ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr  <= TGT_EMPTY;
      dout <= '0;
    end else if (req) begin
      dout <= DATA_W'((ptr == TGT_EMPTY) ? empty_v : full_v);
      ptr  <= (ptr == TGT_EMPTY) ? TGT_FULL : TGT_EMPTY;
    end
  end
endmodule

// File: rtl/fo_offset_regs.sv
module fo_offset_regs #(
  parameter int DEPTH  = 1024,
  parameter int OW     = $clog2(DEPTH),
  parameter int DATA_W = 16,
  parameter int BW     = (OW > 1) ? $clog2(OW) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_mode,
  input  logic [1:0]        dflt_sel,
  input  logic              par_we,
  input  logic [DATA_W-1:0] par_din,
  input  logic              ser_en,
  input  logic              ser_din,
  input  logic              rd_req,
  output logic [OW-1:0]     empty_ofs,
  output logic [OW-1:0]     full_ofs,
  output logic [DATA_W-1:0] rd_data
);
  import fo_pkg::*;

  logic          mode_q;
  logic [OW-1:0] dflt_v;
  logic [OW-1:0] par_v;
  ofs_tgt_e      par_tgt, ser_tgt;
  logic [BW-1:0] ser_idx;
  logic          par_go, ser_go;

  assign par_go = par_we & ~mode_q;
  assign ser_go = ser_en & mode_q;

  fo_defaults #(.DEPTH(DEPTH), .OW(OW)) u_dflt (
    .idx   ({load_mode, dflt_sel}),
    .value (dflt_v)
  );

  fo_par_ctrl #(.DEPTH(DEPTH), .OW(OW), .DATA_W(DATA_W)) u_par (
    .clk     (clk),
    .rst     (rst),
    .step    (par_go),
    .din     (par_din),
    .tgt     (par_tgt),
    .clipped (par_v)
  );

  fo_ser_ctrl #(.OW(OW), .BW(BW)) u_ser (
    .clk     (clk),
    .rst     (rst),
    .step    (ser_go),
    .tgt     (ser_tgt),
    .bit_idx (ser_idx)
  );

  fo_readback #(.OW(OW), .DATA_W(DATA_W)) u_rb (
    .clk     (clk),
    .rst     (rst),
    .req     (rd_req),
    .empty_v (empty_ofs),
    .full_v  (full_ofs),
    .dout    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= load_mode;
      empty_ofs <= dflt_v;
      full_ofs  <= dflt_v;
    end else if (par_go) begin
      if (par_tgt == TGT_EMPTY) empty_ofs <= par_v;
      else                      full_ofs  <= par_v;
    end else if (ser_go) begin
      if (ser_tgt == TGT_EMPTY) empty_ofs[ser_idx] <= ser_din;
      else                      full_ofs[ser_idx]  <= ser_din;
    end
  end
endmodule

// File: rtl/fo_offset_chk.sv
module fo_offset_chk #(
  parameter int OW     = 10,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              serial_mode,
  input logic              par_we,
  input logic              ser_en,
  input logic              rd_req,
  input logic [OW-1:0]     empty_ofs,
  input logic [OW-1:0]     full_ofs,
  input logic [DATA_W-1:0] rd_data
);
  assert_serial_ignores_par_R6: assert property (@(posedge clk) disable iff (rst)
    (serial_mode && !ser_en) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  assert_par_ignores_ser_R6: assert property (@(posedge clk) disable iff (rst)
    (!serial_mode && !par_we) |=> ($stable(empty_ofs) && $stable(full_ofs)));

  assert_one_target_R3: assert property (@(posedge clk) disable iff (rst)
    (!serial_mode && par_we) |=> ($stable(empty_ofs) || $stable(full_ofs)));

  assert_one_bit_R5: assert property (@(posedge clk) disable iff (rst)
    (serial_mode && ser_en) |=>
      ($countones({empty_ofs ^ $past(empty_ofs), full_ofs ^ $past(full_ofs)}) <= 1));

  assert_rd_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> $stable(rd_data));

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> ((rd_data == '0) && (empty_ofs == full_ofs)));
endmodule

bind fo_offset_regs fo_offset_chk #(.OW(OW), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .serial_mode (mode_q),
  .par_we      (par_we),
  .ser_en      (ser_en),
  .rd_req      (rd_req),
  .empty_ofs   (empty_ofs),
  .full_ofs    (full_ofs),
  .rd_data     (rd_data)
);

// File: tb/sim_fo_offset_regs.sv
module sim_fo_offset_regs;
  localparam int DEPTH = 1024;
  localparam int OW = 10;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load_mode = 1'b0;
  logic [1:0] dflt_sel = 2'b00;
  logic par_we = 1'b0;
  logic [DW-1:0] par_din = '0;
  logic ser_en = 1'b0, ser_din = 1'b0, rd_req = 1'b0;
  logic [OW-1:0] empty_ofs, full_ofs;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  fo_offset_regs #(.DEPTH(DEPTH), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .load_mode(load_mode), .dflt_sel(dflt_sel),
    .par_we(par_we), .par_din(par_din), .ser_en(ser_en), .ser_din(ser_din),
    .rd_req(rd_req), .empty_ofs(empty_ofs), .full_ofs(full_ofs), .rd_data(rd_data)
  );

  // {write data, expected empty offset, expected full offset}; starts from default 63
  localparam logic [47:0] VEC [8] = '{
    {16'd100,  16'd100,  16'd63},
    {16'd200,  16'd100,  16'd200},
    {16'd5000, 16'd1023, 16'd200},
    {16'd1023, 16'd1023, 16'd1023},
    {16'd0,    16'd0,    16'd1023},
    {16'd1024, 16'd0,    16'd1023},
    {16'd1022, 16'd1022, 16'd1023},
    {16'd7,    16'd1022, 16'd7}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic mode, input logic [1:0] sel);
    rst = 1'b1; load_mode = mode; dflt_sel = sel;
    tick();
    rst = 1'b0; load_mode = 1'b0; dflt_sel = 2'b00;
  endtask

  task automatic shift_word(input logic [OW-1:0] v);
    for (int b = 0; b < OW; b++) begin
      ser_en = 1'b1; ser_din = v[b];
      tick();
    end
    ser_en = 1'b0; ser_din = 1'b0;
  endtask

  task automatic read_one(input string req, input int exp);
    rd_req = 1'b1;
    tick();
    rd_req = 1'b0;
    check(req, int'(rd_data), exp);
  endtask

  initial begin
    tick();
    // R2 / R8: defaults for all eight indices, read-back cleared
    for (int i = 0; i < 8; i++) begin
      int e;
      e = (1 << (i + 3)) - 1;
      if (e > DEPTH - 1) e = DEPTH - 1;
      do_reset(i[2], i[1:0]);
      check("R2 empty default", int'(empty_ofs), e);
      check("R2 full default", int'(full_ofs), e);
      check("R8 rd_data cleared", int'(rd_data), 0);
    end

    // R3 / R4: parallel vector table
    do_reset(1'b0, 2'b11);
    for (int k = 0; k < 8; k++) begin
      par_we = 1'b1; par_din = VEC[k][47:32];
      tick();
      par_we = 1'b0;
      check("R3/R4 par empty", int'(empty_ofs), int'(VEC[k][31:16]));
      check("R3/R4 par full", int'(full_ofs), int'(VEC[k][15:0]));
    end

    // R6: serial enable ignored in parallel mode (offsets 1022 / 7)
    for (int b = 0; b < 12; b++) begin
      ser_en = 1'b1; ser_din = 1'b1;
      tick();
    end
    ser_en = 1'b0; ser_din = 1'b0;
    check("R6 par mode ignores ser empty", int'(empty_ofs), 1022);
    check("R6 par mode ignores ser full", int'(full_ofs), 7);

    // R7: read-back in parallel mode with wrap
    read_one("R7 rd first empty", 1022);
    read_one("R7 rd then full", 7);
    read_one("R7 rd wraps", 1022);

    // R8: reset mid-order returns write and read order to empty
    par_we = 1'b1; par_din = 16'd11;
    tick();
    par_we = 1'b0;
    rd_req = 1'b1;
    tick();
    rd_req = 1'b0;
    do_reset(1'b0, 2'b00);
    par_we = 1'b1; par_din = 16'd33;
    tick();
    par_we = 1'b0;
    check("R8 write order reset", int'(empty_ofs), 33);
    check("R8 full unchanged", int'(full_ofs), 7);
    read_one("R8 read order reset", 33);

    // R1 / R5: serial mode, default idx 4 = 127
    do_reset(1'b1, 2'b00);
    check("R1 serial default", int'(empty_ofs), 127);
    shift_word(10'h2A5);
    check("R5 serial empty loaded", int'(empty_ofs), 'h2A5);
    check("R5 full untouched yet", int'(full_ofs), 127);
    shift_word(10'h13C);
    check("R5 serial full loaded", int'(full_ofs), 'h13C);
    check("R5 empty kept", int'(empty_ofs), 'h2A5);

    // R6 / R1: parallel strobe ignored in serial mode
    par_we = 1'b1; par_din = 16'd5;
    tick(); tick();
    par_we = 1'b0;
    check("R6 ser mode ignores par empty", int'(empty_ofs), 'h2A5);
    check("R6 ser mode ignores par full", int'(full_ofs), 'h13C);

    // R5: sequence wraps to empty offset
    shift_word(10'h001);
    check("R5 wrap to empty", int'(empty_ofs), 1);
    check("R5 wrap full kept", int'(full_ofs), 'h13C);

    // R7: read-back works in serial mode
    read_one("R7 serial rd empty", 1);
    read_one("R7 serial rd full", 'h13C);

    // R8: serial bit position reset mid-word
    shift_word(10'h3FF);
    ser_en = 1'b1; ser_din = 1'b1;
    tick(); tick(); tick();
    ser_en = 1'b0;
    do_reset(1'b1, 2'b01);
    shift_word(10'h155);
    check("R8 serial restarts at empty", int'(empty_ofs), 'h155);
    check("R8 serial full default", int'(full_ofs), 255);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule